// File: doc/BRIEF.md
# Block-Parity Asynchronous Bus Receiver

This block pulls an even number of bytes from a nine-line, active-low parallel bus (eight data lines plus one parity line) using a four-phase request/acknowledge handshake. While it receives, it drives only its request line; the data and parity lines are inputs. A transfer starts with a one-cycle start pulse that carries the byte count minus one. For each byte the block asserts the request, waits for the acknowledge, samples the bus, drops the request, and waits for the acknowledge to be released before it asks for the next byte.

Bytes are delivered in pairs as 32-bit words. Each lane holds the recovered (inverted) nine-bit value: data in the low eight bits and the parity bit on top. The parity check is made once per block rather than per byte. A running XOR of the raw line levels is kept in two lanes. At the end of the block, a sticky error flag is raised if either lane of that XOR has an odd number of ones. An even number of bad bytes within one lane therefore goes unnoticed. The acknowledge input passes through a synchronizer of configurable depth. An active-low reset aborts a transfer in any phase and releases the request.

Top module: `block_par_rx`

## Requirements
- R1: After reset, req_n is high (released), busy, done and word_valid are low, and par_err is low.
- R2: A start pulse while idle begins a transfer. On the next cycle busy is high and req_n is low.
- R3: The request follows a four-phase handshake. req_n rises only after an acknowledge (ack_n low) has been seen. It stays high while ack_n stays low. It falls again only after the released acknowledge has passed the synchronizer.
- R4: The number of bytes taken is (count_m1 | 1) + 1. Bit 0 of count_m1 is treated as 1, so the count is always even.
- R5: Each pair of captured bytes gives one word_valid pulse of one cycle. In that word, bits 8:0 hold the inverted line levels of the first byte, bits 24:16 hold the inverted line levels of the second byte, and all other bits are zero. The parity bit is bit 8 of each lane.
- R6: At the end of a block, par_err is set if either lane (bits 8:0 or 24:16) of the XOR of all raw captured words has an odd number of ones. A good byte has odd parity across its nine logical bits. par_err is cleared by a start and otherwise holds its value.
- R7: Two bad bytes in the same lane within one block cancel out and leave par_err low. One bad byte in each lane sets it.
- R8: done pulses for exactly one cycle when the last acknowledge is released. busy is low in that same cycle, and req_n stays released while idle.
- R9: A start pulse during a transfer is ignored. The running transfer keeps its original byte count.
- R10: Asserting rst_n low in the middle of a transfer releases req_n and returns to idle. A following transfer delivers its full count with correct pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, aborts any transfer |
| start | input | 1 | One-cycle start pulse, taken only while idle |
| count_m1 | input | CNT_W | Byte count minus one; bit 0 forced to 1 |
| bus_n | input | 9 | Active-low bus lines, bit 8 is parity |
| ack_n | input | 1 | Active-low acknowledge from the sender |
| req_n | output | 1 | Active-low request to the sender |
| word_out | output | 32 | Recovered byte pair, two 9-bit lanes at bits 0 and 16 |
| word_valid | output | 1 | One-cycle strobe for word_out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a block |
| par_err | output | 1 | Sticky block parity error, cleared on start |

## Verification
The bench builds the block with CNT_W = 8 and SYNC_STAGES = 2. The 8-bit counter lets a single test reach the largest block, 256 bytes and 128 words, within a short run. The two-stage synchronizer keeps the handshake delay small enough to watch each phase of the request, including a sender that holds its acknowledge low on purpose. Parity cases corrupt chosen bytes so that each lane gets an odd count, an even count, or no errors.

// File: rtl/block_par_rx_pkg.sv
package block_par_rx_pkg;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = 32;
  localparam int HI_LANE = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_ASK, ST_HOLD} rx_state_e;

  // A lane of the raw XOR is bad when its ones count is odd.
  function automatic logic lane_bad(input logic [LANE_W-1:0] x);
    return ^x;
  endfunction

  // Raw line levels of a pair, in place, ready to XOR into the block sum.
  function automatic logic [WORD_W-1:0] place_raw(input logic [LANE_W-1:0] r, input logic hi);
    logic [WORD_W-1:0] w;
    w = '0;
    if (hi) w[HI_LANE +: LANE_W] = r;
    else    w[0 +: LANE_W] = r;
    return w;
  endfunction

  // Recovered word: both lanes inverted back to logical levels.
  function automatic logic [WORD_W-1:0] pack_pair(input logic [LANE_W-1:0] r0,
                                                  input logic [LANE_W-1:0] r1);
    return place_raw(~r0, 1'b0) | place_raw(~r1, 1'b1);
  endfunction
endpackage

// File: rtl/block_par_rx_hs.sv
module block_par_rx_hs
  import block_par_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count_m1,
  input  logic             ack_n,
  output logic             req_n,
  output logic             busy,
  output logic             done,
  output logic             start_evt,
  output logic             cap_evt,
  output logic             last_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ack_s;
  rx_state_e              st;
  logic [CNT_W-1:0]       rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~ack_n};
  end
  assign ack_s = sync_q[SYNC_STAGES-1];

  assign start_evt = (st == ST_IDLE) && start;
  assign cap_evt   = (st == ST_ASK) && ack_s;
  assign last_evt  = (st == ST_HOLD) && !ack_s && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      rem  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_evt;
      unique case (st)
        ST_IDLE: if (start) begin
          rem <= count_m1 | CNT_W'(1);
          st  <= ST_ASK;
        end
        ST_ASK:  if (ack_s) st <= ST_HOLD;
        ST_HOLD: if (!ack_s) begin
          if (rem == '0) st <= ST_IDLE;
          else begin
            rem <= rem - CNT_W'(1);
            st  <= ST_ASK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_n = (st != ST_ASK);
  assign busy  = (st != ST_IDLE);

  // R3: a new request within a transfer only after the acknowledge was released
  p_req_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_n) && $past(busy)) |-> !$past(ack_s));
  // R8: done is a single-cycle pulse seen while idle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_n));
endmodule

// File: rtl/block_par_rx_pack.sv
module block_par_rx_pack
  import block_par_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              cap_evt,
  input  logic [LANE_W-1:0] bus_n,
  output logic              lane_hi,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);
  logic [LANE_W-1:0] first_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_hi    <= 1'b0;
      first_raw  <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (start_evt) lane_hi <= 1'b0;
      else if (cap_evt) begin
        if (!lane_hi) first_raw <= bus_n;
        else begin
          word_out   <= pack_pair(first_raw, bus_n);
          word_valid <= 1'b1;
        end
        lane_hi <= !lane_hi;
      end
    end
  end

  // R5: one strobe per pair, never back to back
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: rtl/block_par_rx_chk.sv
module block_par_rx_chk
  import block_par_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              start_evt,
  input  logic              cap_evt,
  input  logic              last_evt,
  input  logic              lane_hi,
  input  logic [LANE_W-1:0] bus_n,
  output logic              par_err
);
  logic [WORD_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      par_err <= 1'b0;
    end else begin
      if (start_evt) begin
        acc     <= '0;
        par_err <= 1'b0;
      end else begin
        if (cap_evt) acc <= acc ^ place_raw(bus_n, lane_hi);
        if (last_evt)
          par_err <= lane_bad(acc[0 +: LANE_W]) | lane_bad(acc[HI_LANE +: LANE_W]);
      end
    end
  end

  // R6: the flag does not move in the middle of a transfer
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(par_err));
endmodule

// File: rtl/block_par_rx.sv
module block_par_rx
  import block_par_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count_m1,
  input  logic [LANE_W-1:0] bus_n,
  input  logic              ack_n,
  output logic              req_n,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              busy,
  output logic              done,
  output logic              par_err
);
  logic start_evt, cap_evt, last_evt, lane_hi;

  block_par_rx_hs #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .start(start), .count_m1(count_m1), .ack_n(ack_n),
    .req_n(req_n), .busy(busy), .done(done),
    .start_evt(start_evt), .cap_evt(cap_evt), .last_evt(last_evt));

  block_par_rx_pack u_pack (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .cap_evt(cap_evt),
    .bus_n(bus_n), .lane_hi(lane_hi), .word_out(word_out), .word_valid(word_valid));

  block_par_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_evt(start_evt), .cap_evt(cap_evt),
    .last_evt(last_evt), .lane_hi(lane_hi), .bus_n(bus_n), .par_err(par_err));

  // R1 / R10: while idle the request is released
  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_n);
  // R5: a word is only produced while a transfer runs
  p_word_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(busy));
endmodule

// File: tb/block_par_rx_test.sv
`timescale 1ns/1ps
module block_par_rx_test;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, start = 0, ack_n = 1;
  logic [CW-1:0] count_m1 = '0;
  logic [8:0] bus_n = '1;
  logic req_n, word_valid, busy, done, par_err;
  logic [31:0] word_out;
  int checks = 0, errors = 0;
  logic [31:0] got [0:255];
  int wcount = 0;
  logic [255:0] badmask;

  always #2 clk = ~clk;

  block_par_rx #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .count_m1(count_m1), .bus_n(bus_n),
    .ack_n(ack_n), .req_n(req_n), .word_out(word_out), .word_valid(word_valid),
    .busy(busy), .done(done), .par_err(par_err));

  always @(negedge clk) if (word_valid) begin
    if (wcount < 256) got[wcount] = word_out;
    wcount++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 8'hFF);
  endfunction
  // logical 9-bit code: top bit makes the total ones count odd
  function automatic logic [8:0] code(input logic [7:0] d);
    return {($countones(d) % 2 == 0), d};
  endfunction

  task automatic pulse_start(input int m1);
    @(negedge clk); count_m1 = CW'(m1); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic bad);
    logic [8:0] c;
    while (req_n) @(negedge clk);
    c = code(d);
    c[8] = c[8] ^ bad;
    bus_n = ~c;
    repeat (2) @(negedge clk);
    ack_n = 0;
    while (!req_n) @(negedge clk);
    bus_n = '1;
    @(negedge clk);
    ack_n = 1;
  endtask

  task automatic run_xfer(input int m1, input int seed, input string tag);
    int n;
    int odd0, odd1;
    logic [31:0] e;
    n = (m1 | 1) + 1;
    wcount = 0;
    odd0 = 0; odd1 = 0;
    pulse_start(m1);
    for (int i = 0; i < n; i++) send_byte(pat(i, seed), badmask[i]);
    while (!done) @(negedge clk);
    chk(!busy, {tag, " R8 busy low with done"}, 32'(busy), 0);
    for (int i = 0; i < n; i++) if (badmask[i]) begin
      if (i % 2 == 0) odd0++; else odd1++;
    end
    chk(par_err == ((odd0 % 2) | (odd1 % 2)), {tag, " R6 R7 par_err"}, 32'(par_err),
        32'((odd0 % 2) | (odd1 % 2)));
    @(negedge clk);
    chk(!done, {tag, " R8 done single"}, 32'(done), 0);
    chk(wcount == n / 2, {tag, " R4 word count"}, 32'(wcount), 32'(n / 2));
    for (int k = 0; k < n / 2 && k < wcount; k++) begin
      logic [8:0] a, b;
      a = code(pat(2 * k, seed));     a[8] = a[8] ^ badmask[2 * k];
      b = code(pat(2 * k + 1, seed)); b[8] = b[8] ^ badmask[2 * k + 1];
      e = {7'b0, b, 7'b0, a};
      chk(got[k] == e, {tag, " R5 word"}, got[k], e);
    end
  endtask

  task automatic t_reset;
    chk(req_n && !busy && !done && !word_valid && !par_err, "R1 reset state",
        {27'b0, req_n, busy, done, word_valid, par_err}, 32'h10);
  endtask

  task automatic t_start_and_handshake;
    pulse_start(1);
    chk(!req_n && busy, "R2 request after start", {30'b0, req_n, busy}, 32'h1);
    repeat (6) @(negedge clk);
    chk(!req_n, "R3 request held without ack", 32'(req_n), 0);
    bus_n = ~code(8'h5A); ack_n = 0;
    while (!req_n) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(req_n, "R3 no new request while ack held", 32'(req_n), 1);
    bus_n = '1; ack_n = 1;
    repeat (6) @(negedge clk);
    chk(!req_n, "R3 new request after release", 32'(req_n), 0);
    send_byte(8'hC3, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_busy_start;
    int n = 8;
    wcount = 0;
    pulse_start(7);
    send_byte(8'h11, 0);
    pulse_start(1);
    for (int i = 1; i < n; i++) send_byte(8'(i), 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(wcount == 4, "R9 start ignored while busy", 32'(wcount), 4);
  endtask

  task automatic t_abort;
    pulse_start(7);
    send_byte(8'h21, 0); send_byte(8'h22, 0); send_byte(8'h23, 0);
    while (req_n) @(negedge clk);
    rst_n = 0; ack_n = 1;
    @(negedge clk);
    chk(req_n && !busy, "R10 abort releases request", {30'b0, req_n, busy}, 32'h2);
    rst_n = 1;
    @(negedge clk);
    badmask = '0;
    run_xfer(1, 3, "R10 after abort");
  endtask

  task automatic t_sticky;
    badmask = '0; badmask[2] = 1;
    run_xfer(5, 4, "R6 single bad");
    repeat (5) @(negedge clk);
    chk(par_err, "R6 flag sticky", 32'(par_err), 1);
    pulse_start(1);
    chk(!par_err, "R6 cleared by start", 32'(par_err), 0);
    send_byte(8'h01, 0); send_byte(8'h02, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start_and_handshake();
    badmask = '0; run_xfer(3, 1, "R5 basic");
    badmask = '0; run_xfer(4, 2, "R4 even m1");
    t_sticky();
    badmask = '0; badmask[0] = 1; badmask[4] = 1; run_xfer(7, 5, "R7 even same lane");
    badmask = '0; badmask[1] = 1; badmask[4] = 1; run_xfer(7, 6, "R7 one per lane");
    badmask = '0; badmask[3] = 1; badmask[9] = 1; badmask[11] = 1; run_xfer(15, 7, "R6 three hi");
    t_busy_start();
    t_abort();
    badmask = '0; run_xfer(255, 8, "R4 full range");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule